// File: doc/BRIEF.md
# Masked Fault Register with Delayed Self-Clear

This block gathers eight digital fault flags from a supply supervisor: an under-limit and an over-limit window comparator for each of three rails, plus an overload flag and a malfunction flag. It records them in an 8-bit fault status register. A detected fault pulls its bit to 0, so a 1 means healthy. An 8-bit reporting mask chooses which recorded faults drive a static active-low fail output.

Reported faults clear themselves after a quiet period. This happens once no reported fault has been present for a programmable number of milliseconds (25 by default), counted from a clock-derived millisecond timebase. Unreported bits are never touched by this clear. If a fault is reported while a self-test is running, the fail output is held low until the next self-test starts.

A serial link reads the register through a snapshot port, which is captured on a strobe. The same link writes a new mask through a load strobe.

Top module: `fault_mask_reg`

## Requirements
- R1: After reset the status register reads 8'hFF, the mask reads 8'hFF (every fault reported), the snapshot reads 8'hFF and fail_n is 1.
- R2: A 1 on fault_det[i], sampled on a clock edge, drives status bit i to 0 after that edge. The bit stays 0 until it is restored. Bit mapping: 0 rail 1 under, 1 rail 1 over, 2 rail 2 under, 3 rail 2 over, 4 rail 3 under, 5 rail 3 over, 6 overload, 7 malfunction.
- R3: fail_n is 0 exactly when some status bit is 0 and its mask bit is 1.
- R4: When the last reported fault input falls, the status bits that are 0 and whose mask bit is 1 are set back to 1. This happens after CLEAR_MS*CLK_PER_MS clock edges, counted from the first edge that samples no reported fault. fail_n then returns to 1.
- R5: A status bit whose mask bit is 0 is never set back to 1 by the delayed clear.
- R6: While any fault input with its mask bit set is 1, no status bit is restored, and the delay count starts over.
- R7: mask_load high at an edge copies mask_in into the mask. Without it the mask keeps its value.
- R8: snap_req high at an edge copies the pre-edge status value to snap_o. Without it snap_o keeps its value.
- R9: If a reported fault input is 1 at an edge while test_busy is 1, no status bit is restored until test_busy next rises. The delay count then runs from that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_det | input | NFLAG | Fault flags, 1 = fault present |
| test_busy | input | 1 | High while a self-test runs |
| mask_load | input | 1 | Mask write strobe |
| mask_in | input | NFLAG | New mask value |
| snap_req | input | 1 | Snapshot capture strobe |
| fir_o | output | NFLAG | Live status register, 0 = fault seen |
| mask_o | output | NFLAG | Current reporting mask |
| snap_o | output | NFLAG | Captured status for the serial link |
| fail_n | output | 1 | Active-low fail indicator |

## Verification
The bench times the restore down to the single edge, checking the state one edge before the deadline and again on it. An off-by-one delay counter would fail at one of those two samples. It clears a masked-out bit and a reported bit together, then checks that only the reported bit returns; a clear that ignored the mask would also bring back the unreported bit. A reported fault raised during a self-test must keep fail_n low across a long idle stretch and release only after the next test begins. A design that let the timer run in idle would release early. Random flags, mask writes, snapshots and test windows are compared against a cycle model on every edge.

// File: rtl/fault_mask_reg.sv
module fault_mask_reg #(
  parameter int NFLAG      = 8,
  parameter int CLK_PER_MS = 250000,
  parameter int CLEAR_MS   = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] fault_det,
  input  logic             test_busy,
  input  logic             mask_load,
  input  logic [NFLAG-1:0] mask_in,
  input  logic             snap_req,
  output logic [NFLAG-1:0] fir_o,
  output logic [NFLAG-1:0] mask_o,
  output logic [NFLAG-1:0] snap_o,
  output logic             fail_n
);

  localparam int CYC_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int MS_W  = (CLEAR_MS > 1) ? $clog2(CLEAR_MS) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(CLEAR_MS - 1);

  logic [NFLAG-1:0] fir_q, mask_q, snap_q;
  logic [CYC_W-1:0] cyc_q;
  logic [MS_W-1:0]  ms_q;
  logic             hold_q, busy_q;

  wire rep_active = |(fault_det & mask_q);
  wire rep_seen   = |(~fir_q & mask_q);
  wire pending    = rep_seen && !rep_active && !hold_q;
  wire cyc_wrap   = (cyc_q == CYC_LAST);
  wire fire       = pending && cyc_wrap && (ms_q == MS_LAST);
  wire busy_rise  = test_busy && !busy_q;

  // status bits: detection wins over the delayed restore
  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               fir_q[i] <= 1'b1;
      else if (fault_det[i])    fir_q[i] <= 1'b0;
      else if (fire && mask_q[i]) fir_q[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ms_q  <= '0;
    end else if (!pending) begin
      cyc_q <= '0;
      ms_q  <= '0;
    end else if (cyc_wrap) begin
      cyc_q <= '0;
      ms_q  <= (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= test_busy;
      if (busy_rise)                    hold_q <= 1'b0;
      else if (test_busy && rep_active) hold_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '1;
    else if (mask_load) mask_q <= mask_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_q <= '1;
    else if (snap_req) snap_q <= fir_q;
  end

  assign fir_o  = fir_q;
  assign mask_o = mask_q;
  assign snap_o = snap_q;
  assign fail_n = !rep_seen;

  AST_DET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_det != '0) |=> ((fir_q & $past(fault_det)) == '0)); // R2
  AST_UNREPORTED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fir_q & ~$past(fir_q) & ~$past(mask_q)) == '0)); // R5
  AST_ACTIVE_NO_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_active |=> ((fir_q & ~$past(fir_q)) == '0)); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_load |=> $stable(mask_q)); // R7
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> $stable(snap_q)); // R8
  AST_HOLD_NO_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> ((fir_q & ~$past(fir_q)) == '0)); // R9

endmodule

// File: tb/test_fault_mask_reg.sv
module test_fault_mask_reg;
  localparam int CPM = 8;
  localparam int CMS = 25;
  localparam int N   = CPM * CMS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fault_det = '0;
  logic       test_busy = 1'b0;
  logic       mask_load = 1'b0;
  logic [7:0] mask_in = '0;
  logic       snap_req = 1'b0;
  logic [7:0] fir_o, mask_o, snap_o;
  logic       fail_n;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  logic [7:0] m_fir, m_mask, m_snap;
  int         m_cnt;
  logic       m_hold, m_busy_q;

  always #2 clk = ~clk;

  fault_mask_reg #(.NFLAG(8), .CLK_PER_MS(CPM), .CLEAR_MS(CMS)) i_fault_mask_reg (
    .clk(clk), .rst_n(rst_n), .fault_det(fault_det), .test_busy(test_busy),
    .mask_load(mask_load), .mask_in(mask_in), .snap_req(snap_req),
    .fir_o(fir_o), .mask_o(mask_o), .snap_o(snap_o), .fail_n(fail_n));

  function automatic logic exp_fail_n(logic [7:0] f, logic [7:0] m);
    return !(|(~f & m));
  endfunction

  function automatic logic [7:0] exp_fir(logic [7:0] f, logic [7:0] m, logic [7:0] d, bit fire);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = d[i] ? 1'b0 : ((fire && m[i]) ? 1'b1 : f[i]);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (model_on) begin
      bit act, pend, fire;
      logic [7:0] old_fir;
      act  = |(fault_det & m_mask);
      pend = (|(~m_fir & m_mask)) && !act && !m_hold;
      fire = pend && (m_cnt == N - 1);
      old_fir = m_fir;
      m_fir = exp_fir(m_fir, m_mask, fault_det, fire);
      m_cnt = (pend && !fire) ? m_cnt + 1 : 0;
      if (test_busy && !m_busy_q) m_hold = 1'b0;
      else if (test_busy && act)  m_hold = 1'b1;
      m_busy_q = test_busy;
      if (snap_req)  m_snap = old_fir;
      if (mask_load) m_mask = mask_in;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 fir", fir_o, 8'hFF);
    chk("R1 mask", mask_o, 8'hFF);
    chk("R1 snap", snap_o, 8'hFF);
    chk("R1 fail_n", fail_n, 1'b1);

    // R2 R3 R4: rail 2 over (bit3)
    fault_det = 8'h08; step(1);
    fault_det = 8'h00;
    chk("R2 bit3 cleared", fir_o, 8'hF7);
    chk("R3 fail low", fail_n, 1'b0);
    snap_req = 1'b1; step(1); snap_req = 1'b0;
    chk("R8 snapshot", snap_o, 8'hF7);
    step(N - 2);
    chk("R4 still cleared at N-1", fir_o, 8'hF7);
    chk("R4 fail still low", fail_n, 1'b0);
    step(1);
    chk("R4 restored at N", fir_o, 8'hFF);
    chk("R4 fail released", fail_n, 1'b1);
    chk("R8 snap held", snap_o, 8'hF7);

    // R7 mask load; R5 unreported bit kept
    mask_in = 8'hFE; mask_load = 1'b1; step(1); mask_load = 1'b0; mask_in = 8'h00;
    chk("R7 mask loaded", mask_o, 8'hFE);
    step(5);
    chk("R7 mask held", mask_o, 8'hFE);
    fault_det = 8'h21; step(1); fault_det = 8'h00;
    chk("R2 bits0,5 cleared", fir_o, 8'hDE);
    step(N);
    chk("R5 unreported bit kept", fir_o, 8'hFE);
    chk("R3 fail released with masked bit", fail_n, 1'b1);
    fault_det = 8'h01; step(1); fault_det = 8'h00;
    chk("R3 masked fault no fail", fail_n, 1'b1);
    mask_in = 8'hFF; mask_load = 1'b1; step(1); mask_load = 1'b0;
    chk("R3 unmasked old fault fails", fail_n, 1'b0);
    step(N);
    chk("R4 restored after unmask", fir_o, 8'hFF);

    // R6 long active fault restarts the count
    fault_det = 8'h40; step(3 * N);
    chk("R6 no restore while active", fir_o, 8'hBF);
    fault_det = 8'h00; step(N - 1);
    chk("R6 count restarted", fir_o, 8'hBF);
    step(1);
    chk("R6 restore after quiet", fir_o, 8'hFF);

    // R9 fault during self-test holds fail
    test_busy = 1'b1; step(2);
    fault_det = 8'h04; step(1); fault_det = 8'h00;
    step(2); test_busy = 1'b0;
    step(3 * N);
    chk("R9 held after test", fir_o, 8'hFB);
    chk("R9 fail held low", fail_n, 1'b0);
    test_busy = 1'b1; step(1); test_busy = 1'b0;
    step(N - 1);
    chk("R9 still held before N", fir_o, 8'hFB);
    step(1);
    chk("R9 released after next test", fir_o, 8'hFF);
    chk("R9 fail released", fail_n, 1'b1);

    // random phase against the model
    rst_n = 1'b0; step(2);
    m_fir = 8'hFF; m_mask = 8'hFF; m_snap = 8'hFF; m_cnt = 0;
    m_hold = 1'b0; m_busy_q = 1'b0;
    fault_det = '0; test_busy = 1'b0; mask_load = 1'b0; snap_req = 1'b0;
    rst_n = 1'b1; model_on = 1'b1;
    for (int k = 0; k < 6000; k++) begin
      fault_det = ($urandom % 40 == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
      mask_load = ($urandom % 300 == 0);
      mask_in   = 8'($urandom);
      snap_req  = ($urandom % 16 == 0);
      if ($urandom % 500 == 0) test_busy = !test_busy;
      step(1);
      chk("R2 R4 random fir", fir_o, m_fir);
      chk("R3 random fail_n", fail_n, exp_fail_n(m_fir, m_mask));
      chk("R7 random mask", mask_o, m_mask);
      chk("R8 random snap", snap_o, m_snap);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule